// File: doc/BRIEF.md
# Ten-Channel Fixed-Priority Single-Transfer DMA Engine

The engine serves ten channels. Each one moves a single data word from a source address to a destination address, one word per accepted request. A channel can be triggered in two ways. The first is a level-sampled request line. The second is an external pin, which passes through a two-flop synchronizer and an edge detector that can be set to fire on rising edges, falling edges or both. When a request is accepted it is latched as pending. When more than one channel is pending, the lowest-numbered channel always wins, and software cannot change this order.

For each transfer the engine raises a bus request to the CPU side and waits for the grant. It then performs exactly one read cycle and one write cycle and drops the request. The bus stays with the CPU for at least one cycle before arbitration runs again.

Each channel has a source address, a destination address and a transfer count. Both addresses step by one after every transfer. When the count runs out, the channel turns itself off and raises its done flag. Software sets up the channels through a write-only configuration port.

Top module: `dma_single_xfer`

## Requirements
- R1: After reset, bus_req, mem_rd and mem_wr are low, mem_addr is zero and every done bit is clear.
- R2: When several enabled channels are pending, the transfer order follows channel number, with the lowest number first.
- R3: A channel with its enable bit (control bit 0) at 0 never transfers. A channel set to one source (control bit 1: 0 = request line, 1 = trigger pin) ignores activity on the other source.
- R4: The trigger edge mode is control bits 3:2. The codes are 01 for rising, 10 for falling, 11 for both and 00 for none. Each detected edge gives one transfer, and edges the mode does not select give none.
- R5: A transfer is one mem_rd cycle at the source address, followed in the next cycle by one mem_wr cycle at the destination address carrying the word that was read. The address, rd and wr lines are active only while bus_gnt is high, and nothing starts until the grant arrives.
- R6: In the cycle after mem_wr, bus_req is low, and once it falls it stays low for at least one more cycle.
- R7: One accepted request gives exactly one transfer. The pending flag clears when that transfer completes.
- R8: Both addresses increment by one after each transfer, and the count (field 3) decrements. A transfer that takes the count to zero clears the enable bit and sets that channel's done bit.
- R9: Suppose the grant answers the request one cycle later and the engine is idle. Then mem_rd first appears in the sixth clock cycle after a selected trigger pin change.
- R10: A write to a channel's control field (field 0) clears that channel's done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NCH | Per-channel request lines, sampled each cycle |
| trig_i | input | NCH | Per-channel asynchronous trigger pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel being written |
| cfg_fld | input | 2 | Field: 0 control, 1 source, 2 destination, 3 count |
| cfg_wdata | input | AW | Write data |
| bus_gnt | input | 1 | Bus grant from the CPU side |
| mem_rdata | input | DW | Read data |
| bus_req | output | 1 | Bus request to the CPU side |
| mem_addr | output | AW | Bus address, zero unless granted |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| done | output | NCH | Per-channel count-exhausted flags |

## Verification
If pending or priority state is wrong, the next mem_rd shows it within a few cycles: the read lands on the wrong source address, or the channel order breaks. If a pending flag fails to clear, a second unrequested transfer appears about five cycles after the first one ends. If the sequencer runs away, mem_rd or mem_wr shows up without the grant, or bus_req stays high across the release gap, and both can be seen in the very cycle they happen. Errors in the address or count registers show up at the next transfer of that channel, as a wrong address or a wrong done bit.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_GAP
  } dma_st_e;

  localparam logic [1:0] FLD_CTRL = 2'd0;
  localparam logic [1:0] FLD_SRC  = 2'd1;
  localparam logic [1:0] FLD_DST  = 2'd2;
  localparam logic [1:0] FLD_CNT  = 2'd3;

  // mode[0] selects rising, mode[1] selects falling
  function automatic logic edge_hit(logic [1:0] mode, logic cur, logic prev);
    return (mode[0] & cur & ~prev) | (mode[1] & ~cur & prev);
  endfunction
endpackage

// File: rtl/dma_edge_det.sv
module dma_edge_det (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       evt
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign evt = dma_pkg::edge_hit(mode, s2_q, prev_q);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 10,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] ready,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    any = |ready;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ready[i]) idx = CHW'(i);
    end
  end
endmodule

// File: rtl/dma_single_xfer.sv
module dma_single_xfer #(
  parameter int NCH = 10,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] trig_i,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_fld,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           bus_gnt,
  input  logic [DW-1:0]  mem_rdata,
  output logic           bus_req,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_wdata,
  output logic [NCH-1:0] done
);
  import dma_pkg::*;

  logic [NCH-1:0] en_q, srcsel_q, pend_q, done_q;
  logic [1:0]     mode_q [NCH];
  logic [AW-1:0]  src_q  [NCH];
  logic [AW-1:0]  dst_q  [NCH];
  logic [CW-1:0]  cnt_q  [NCH];
  dma_st_e        st_q;
  logic [CHW-1:0] act_q;
  logic [DW-1:0]  data_q;

  // named internal events
  logic [NCH-1:0] trig_evt, set_vec, ready_vec;
  logic           arb_any, xfer_start, xfer_end, drive;
  logic [CHW-1:0] arb_ch;

  for (genvar g = 0; g < NCH; g++) begin : g_trig
    dma_edge_det u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (trig_i[g]),
      .mode (mode_q[g]),
      .evt  (trig_evt[g])
    );
    assign set_vec[g] = en_q[g] & (srcsel_q[g] ? trig_evt[g] : req_i[g]);
  end

  assign ready_vec = pend_q & en_q;

  dma_prio_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .ready(ready_vec),
    .any  (arb_any),
    .idx  (arb_ch)
  );

  assign xfer_start = (st_q == ST_IDLE) && arb_any;
  assign xfer_end   = (st_q == ST_WR);

  // channel state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      srcsel_q <= '0;
      pend_q   <= '0;
      done_q   <= '0;
      for (int i = 0; i < NCH; i++) begin
        mode_q[i] <= '0;
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (!en_q[i])          pend_q[i] <= 1'b0;
        else if (set_vec[i])   pend_q[i] <= 1'b1;
        else if (xfer_end && act_q == CHW'(i)) pend_q[i] <= 1'b0;

        if (xfer_end && act_q == CHW'(i)) begin
          src_q[i] <= src_q[i] + AW'(1);
          dst_q[i] <= dst_q[i] + AW'(1);
          cnt_q[i] <= cnt_q[i] - CW'(1);
          if (cnt_q[i] == CW'(1)) begin
            en_q[i]   <= 1'b0;
            done_q[i] <= 1'b1;
          end
        end

        if (cfg_we && cfg_ch == CHW'(i)) begin
          case (cfg_fld)
            FLD_CTRL: begin
              en_q[i]     <= cfg_wdata[0];
              srcsel_q[i] <= cfg_wdata[1];
              mode_q[i]   <= cfg_wdata[3:2];
              done_q[i]   <= 1'b0;
            end
            FLD_SRC: src_q[i] <= cfg_wdata;
            FLD_DST: dst_q[i] <= cfg_wdata;
            default: cnt_q[i] <= cfg_wdata[CW-1:0];
          endcase
        end
      end
    end
  end

  // transfer sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      act_q  <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (arb_any) begin
          act_q <= arb_ch;
          st_q  <= ST_REQ;
        end
        ST_REQ:  if (bus_gnt) st_q <= ST_RD;
        ST_RD: begin
          data_q <= mem_rdata;
          st_q   <= ST_WR;
        end
        ST_WR:   st_q <= ST_GAP;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req   = (st_q == ST_REQ) || (st_q == ST_RD) || (st_q == ST_WR);
  assign drive     = bus_gnt && ((st_q == ST_RD) || (st_q == ST_WR));
  assign mem_rd    = drive && (st_q == ST_RD);
  assign mem_wr    = drive && (st_q == ST_WR);
  assign mem_addr  = !drive ? '0 : (mem_rd ? src_q[act_q] : dst_q[act_q]);
  assign mem_wdata = mem_wr ? data_q : '0;
  assign done      = done_q;
endmodule

// File: rtl/dma_single_xfer_chk.sv
module dma_single_xfer_chk #(
  parameter int NCH = 10,
  parameter int AW  = 16,
  parameter int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] ready_vec,
  input logic           xfer_start,
  input logic [CHW-1:0] arb_ch
);
  localparam logic [NCH-1:0] ONE = NCH'(1);

  p_drive_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_gnt);

  p_quiet_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |-> (mem_addr == '0));

  p_rd_then_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !bus_req);

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |=> !bus_req);

  p_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (ready_vec[arb_ch] && ((ready_vec & ((ONE << arb_ch) - ONE)) == '0)));

  p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~$past(done)) != '0) |-> $past(mem_wr));
endmodule

bind dma_single_xfer dma_single_xfer_chk #(.NCH(NCH), .AW(AW), .CHW(CHW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .done      (done),
  .ready_vec (ready_vec),
  .xfer_start(xfer_start),
  .arb_ch    (arb_ch)
);

// File: tb/sim_dma_single_xfer.sv
module sim_dma_single_xfer;
  localparam int NCH = 10;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] req_i = '0, trig_i = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_ch = '0;
  logic [1:0] cfg_fld = '0;
  logic [15:0] cfg_wdata = '0;
  logic bus_gnt, hold_gnt = 1'b0;
  logic [15:0] mem_rdata, mem_addr, mem_wdata;
  logic bus_req, mem_rd, mem_wr;
  logic [NCH-1:0] done;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  bit seen;
  int waited;
  logic [15:0] ra, wa, wd;

  always #5 clk = ~clk;

  dma_single_xfer u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .trig_i(trig_i),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
    .bus_gnt(bus_gnt), .mem_rdata(mem_rdata), .bus_req(bus_req),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .done(done)
  );

  // CPU side grants one cycle after the request; memory returns address ^ KEY
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req & ~hold_gnt;
  assign mem_rdata = mem_addr ^ KEY;

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(int ch, logic [1:0] fld, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_fld = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // ctrl: bit0 enable, bit1 trigger source, bits3:2 edge mode
  task automatic setup(int ch, logic [15:0] s, logic [15:0] d, int cnt, logic [3:0] ctrl);
    cfg_wr(ch, 2'd1, s);
    cfg_wr(ch, 2'd2, d);
    cfg_wr(ch, 2'd3, 16'(cnt));
    cfg_wr(ch, 2'd0, {12'h0, ctrl});
  endtask

  task automatic pulse_req(logic [NCH-1:0] m);
    @(negedge clk); req_i = m;
    @(negedge clk); req_i = '0;
  endtask

  task automatic get_xfer(int lim);
    seen = 1'b0; waited = 0;
    for (int n = 1; n <= lim; n++) begin
      @(negedge clk);
      if (mem_rd) begin seen = 1'b1; waited = n; break; end
    end
    if (seen) begin
      ra = mem_addr;
      @(negedge clk);
      wa = mem_addr; wd = mem_wdata;
      check("R5 write follows read", int'(mem_wr), 1);
      @(negedge clk);
      check("R6 bus released after write", int'(bus_req), 0);
    end
  endtask

  task automatic expect_xfer(string tag, logic [15:0] s, logic [15:0] d);
    get_xfer(40);
    check({tag, " transfer seen"}, int'(seen), 1);
    check({tag, " read addr"}, int'(ra), int'(s));
    check({tag, " write addr"}, int'(wa), int'(d));
    check({tag, " write data"}, int'(wd), int'(s ^ KEY));
  endtask

  task automatic expect_none(string tag);
    get_xfer(20);
    check({tag, " no transfer"}, int'(seen), 0);
  endtask

  // {channel, source, destination}
  localparam logic [35:0] VEC [4] = '{
    {4'd0, 16'h0010, 16'h0020},
    {4'd9, 16'h1234, 16'h4321},
    {4'd5, 16'hFFF0, 16'h0ABC},
    {4'd2, 16'h8000, 16'h7FFF}
  };

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 bus_req", int'(bus_req), 0);
    check("R1 mem_rd", int'(mem_rd), 0);
    check("R1 mem_wr", int'(mem_wr), 0);
    check("R1 mem_addr", int'(mem_addr), 0);
    check("R1 done", int'(done), 0);

    // table walk: single transfer, done, done clear
    foreach (VEC[k]) begin
      int ch;
      ch = int'(VEC[k][35:32]);
      setup(ch, VEC[k][31:16], VEC[k][15:0], 1, 4'b0001);
      pulse_req(NCH'(1) << ch);
      expect_xfer("R5 table", VEC[k][31:16], VEC[k][15:0]);
      check("R8 done after last transfer", int'(done[ch]), 1);
      cfg_wr(ch, 2'd0, 16'h0000);
      check("R10 done cleared by control write", int'(done[ch]), 0);
    end

    // R2 fixed priority
    setup(7, 16'h0700, 16'h0710, 1, 4'b0001);
    setup(3, 16'h0300, 16'h0310, 1, 4'b0001);
    setup(5, 16'h0500, 16'h0510, 1, 4'b0001);
    pulse_req(NCH'(10'b0010101000));
    expect_xfer("R2 first ch3", 16'h0300, 16'h0310);
    expect_xfer("R2 second ch5", 16'h0500, 16'h0510);
    expect_xfer("R2 third ch7", 16'h0700, 16'h0710);

    // R7 one request one transfer, R8 increments and count exhaustion
    setup(4, 16'h0040, 16'h0080, 3, 4'b0001);
    pulse_req(NCH'(1) << 4);
    expect_xfer("R7 single", 16'h0040, 16'h0080);
    expect_none("R7 pending cleared");
    @(negedge clk); req_i[4] = 1'b1;
    expect_xfer("R8 incremented 1", 16'h0041, 16'h0081);
    expect_xfer("R8 incremented 2", 16'h0042, 16'h0082);
    expect_none("R8 enable cleared at zero count");
    check("R8 done ch4", int'(done[4]), 1);
    @(negedge clk); req_i[4] = 1'b0;

    // R3 unselected source and disabled channel
    setup(6, 16'h0600, 16'h0610, 1, 4'b0111);
    pulse_req(NCH'(1) << 6);
    expect_none("R3 request line ignored on trigger source");
    setup(8, 16'h0800, 16'h0810, 1, 4'b0000);
    pulse_req(NCH'(1) << 8);
    expect_none("R3 disabled channel");
    check("R3 no done", int'(done[8] | done[6]), 0);

    // R9 latency and R4 edge modes on channel 2
    setup(2, 16'h0200, 16'h0220, 20, 4'b0111);
    trig_i[2] = 1'b1;
    expect_xfer("R9 rising", 16'h0200, 16'h0220);
    check("R9 start latency", waited, 6);
    trig_i[2] = 1'b0;
    expect_none("R4 falling ignored in rising mode");
    cfg_wr(2, 2'd0, 16'h000B);
    trig_i[2] = 1'b1;
    expect_none("R4 rising ignored in falling mode");
    trig_i[2] = 1'b0;
    expect_xfer("R4 falling", 16'h0201, 16'h0221);
    cfg_wr(2, 2'd0, 16'h000F);
    trig_i[2] = 1'b1;
    expect_xfer("R4 both rise", 16'h0202, 16'h0222);
    trig_i[2] = 1'b0;
    expect_xfer("R4 both fall", 16'h0203, 16'h0223);
    cfg_wr(2, 2'd0, 16'h0003);
    trig_i[2] = 1'b1;
    expect_none("R4 mode none");

    // R5 nothing moves before grant
    hold_gnt = 1'b1;
    setup(0, 16'h00A0, 16'h00B0, 1, 4'b0001);
    pulse_req(NCH'(1));
    begin
      bit bad;
      bad = 1'b0;
      for (int n = 0; n < 10; n++) begin
        @(negedge clk);
        if (mem_rd || mem_wr || mem_addr != 16'h0) bad = 1'b1;
      end
      check("R5 idle bus without grant", int'(bad), 0);
      check("R5 request held while waiting", int'(bus_req), 1);
    end
    hold_gnt = 1'b0;
    expect_xfer("R5 after grant", 16'h00A0, 16'h00B0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule